// File: doc/BRIEF.md
# Frame Sync Input Qualifier

This block decides whether an external frame-sync input can be trusted for output alignment. One of several sync pins is chosen by a source-select field. The choice is only valid when the active timing reference has a sync pin tied to it. The chosen pin is resampled into the system clock domain and its falling edges are compared against a local 2 kHz boundary tick, which is supplied from outside the block.

The sync input becomes qualified only after a long, unbroken run of boundary ticks, each of which coincides with a falling edge. A single boundary tick without a coincident falling edge removes qualification at once. A missing, malformed or off-phase sync therefore never qualifies. After a phase disturbance, the sync needs a full new run of matching periods before it is trusted again.

Control is a small state machine with three states:
- `ST_OFF`: the sync is not usable.
- `ST_HUNT`: matching periods are being counted.
- `ST_LOCK`: the sync is qualified.

Transitions:
- `OFF→HUNT`: the sync becomes usable.
- `HUNT→HUNT`: on a hit the count advances; on a miss the count clears.
- `HUNT→LOCK`: the final hit of the run arrives.
- `LOCK→HUNT`: a miss occurs.
- `any→OFF`: external sync is disabled or no pin is associated.

Top module: `fsq_top`

## Requirements
- R1: After reset, `qualified_o` is 0.
- R2: Only falling edges of the selected pin count. A waveform whose rising edge lands on the boundary tick never qualifies.
- R3: A pin that falls low is first seen at a clock edge k. That fall counts as a hit when `tick_i` is high at edge k+2. `qualified_o` rises at the clock edge that samples hit number `QUAL_COUNT` (default 64) in an unbroken run. It is still 0 after `QUAL_COUNT`-1 hits.
- R4: While qualified, a `tick_i` cycle without a coincident falling edge clears `qualified_o` at that same clock edge, and the hit count restarts from zero.
- R5: A falling edge that is one clock early or one clock late relative to the tick is not a hit. Such a sync never qualifies.
- R6: After a single missed period, a sync back on the boundary needs `QUAL_COUNT` fresh hits to requalify.
- R7: While `ext_en_i` is 0, `qualified_o` is 0 from the next clock edge on, whatever the pins do.
- R8: `src_sel_i` values 0, 1 and 2 select pin 0, 1 and 2. Activity on unselected pins has no effect.
- R9: When `ref_has_pin_i` is 0, or `src_sel_i` is 3, the sync is inactive and `qualified_o` stays 0.
- R10: While qualified, `qualified_o` stays 1 through any number of further hits; the hit count saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin_i | input | NUM_PINS (3) | Raw asynchronous sync pins |
| tick_i | input | 1 | One-cycle 2 kHz boundary pulse |
| ext_en_i | input | 1 | External frame sync enable |
| src_sel_i | input | SEL_W (2) | Sync pin select; values at or above NUM_PINS select no pin |
| ref_has_pin_i | input | 1 | Active reference has an associated sync pin |
| qualified_o | output | 1 | Sync qualified level |

## Verification
The bench builds the block with its default values: three pins and a run length of 64. This makes the 63-versus-64 hit boundary, the saturation of the count and the full requalification run visible within a few thousand cycles, using an 8-cycle tick period. A behavioural model built on a history queue of pin samples predicts `qualified_o` on every clock. The model covers sources that are off-phase by one cycle, inverted and held static, as well as pin switching and disabling.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } fsq_state_e;
endpackage

// File: rtl/fsq_resync.sv
module fsq_resync #(
    parameter int NUM_PINS = 3,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_i,
    output logic [NUM_PINS-1:0] sync_o
);
    // one flop chain per pin, reset to the idle (high) level
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw_i[g]};
            end
        end
        assign sync_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/fsq_src_mux.sv
module fsq_src_mux #(
    parameter int NUM_PINS = 3,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                ext_en_i,
    input  logic                has_pin_i,
    output logic                active_o,
    output logic                fall_o
);
    logic sel_ok;
    logic picked;
    logic level;
    logic level_q;

    always_comb begin
        sel_ok = 1'b0;
        picked = 1'b1;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                sel_ok = 1'b1;
                picked = sync_i[i];
            end
        end
    end

    assign active_o = ext_en_i & has_pin_i & sel_ok;
    // an inactive source is parked high, so it never produces a fall
    assign level    = active_o ? picked : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else begin
            level_q <= level;
        end
    end

    assign fall_o = level_q & ~level;
endmodule

// File: rtl/fsq_qual_fsm.sv
module fsq_qual_fsm
    import fsq_pkg::*;
#(
    parameter int QUAL_COUNT = 64,
    parameter int CNT_W      = $clog2(QUAL_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic             fall_i,
    output logic             qualified_o,
    output fsq_state_e       state_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_COUNT - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QUAL_COUNT);

    fsq_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             qual_q;
    logic             hit, miss;

    assign hit  = tick_i & fall_i;
    assign miss = tick_i & ~fall_i;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!active_i) begin
            state_n = ST_OFF;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_n = ST_HUNT;
                    cnt_n   = '0;
                end
                ST_HUNT: begin
                    if (hit) begin
                        if (cnt_q >= CNT_LAST) begin
                            state_n = ST_LOCK;
                            cnt_n   = CNT_FULL;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end else if (miss) begin
                        cnt_n = '0;
                    end
                end
                ST_LOCK: begin
                    if (miss) begin
                        state_n = ST_HUNT;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = CNT_FULL;
                    end
                end
                default: begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= 1'b0;
        end else begin
            qual_q <= (state_n == ST_LOCK);
        end
    end

    assign qualified_o = qual_q;
    assign state_o     = state_q;
    assign count_o     = cnt_q;
endmodule

// File: rtl/fsq_top.sv
module fsq_top
    import fsq_pkg::*;
#(
    parameter int NUM_PINS   = 3,
    parameter int QUAL_COUNT = 64,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W      = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_pin_i,
    input  logic                tick_i,
    input  logic                ext_en_i,
    input  logic [SEL_W-1:0]    src_sel_i,
    input  logic                ref_has_pin_i,
    output logic                qualified_o
);
    localparam int CNT_W = $clog2(QUAL_COUNT + 1);

    logic [NUM_PINS-1:0] pins_sync;
    logic                active_w;
    logic                fall_w;
    fsq_state_e          state_w;
    logic [CNT_W-1:0]    count_w;

    fsq_resync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_resync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sync_pin_i),
        .sync_o (pins_sync)
    );

    fsq_src_mux #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (pins_sync),
        .sel_i     (src_sel_i),
        .ext_en_i  (ext_en_i),
        .has_pin_i (ref_has_pin_i),
        .active_o  (active_w),
        .fall_o    (fall_w)
    );

    fsq_qual_fsm #(.QUAL_COUNT(QUAL_COUNT), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active_w),
        .tick_i      (tick_i),
        .fall_i      (fall_w),
        .qualified_o (qualified_o),
        .state_o     (state_w),
        .count_o     (count_w)
    );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
    parameter int QUAL_COUNT = 64,
    parameter int CNT_W      = $clog2(QUAL_COUNT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             ext_en_i,
    input logic             ref_has_pin_i,
    input logic             active,
    input logic             fall,
    input logic [CNT_W-1:0] count,
    input logic             qualified_o
);
    // R4: a boundary without a falling edge drops qualification
    p_drop_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick_i && !fall) |=> !qualified_o);

    // R3: qualification only ever begins on a hit
    p_rise_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified_o) |-> $past(tick_i && fall && active));

    // R7: disabled external sync never qualifies
    p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en_i |=> !qualified_o);

    // R9: no associated pin never qualifies
    p_nopin_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_has_pin_i |=> !qualified_o);

    // R10: without a boundary, a qualified sync stays qualified
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (qualified_o && active && !tick_i) |=> qualified_o);

    // R10: count never exceeds the run length
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(QUAL_COUNT));
endmodule

bind fsq_top fsq_checker #(.QUAL_COUNT(QUAL_COUNT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .ext_en_i      (ext_en_i),
    .ref_has_pin_i (ref_has_pin_i),
    .active        (active_w),
    .fall          (fall_w),
    .count         (count_w),
    .qualified_o   (qualified_o)
);

// File: tb/fsq_top_test.sv
module fsq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 8;
    localparam int RUN        = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sync_pin_i = 3'b111;
    logic       tick_i = 1'b0;
    logic       ext_en_i = 1'b1;
    logic [1:0] src_sel_i = 2'd0;
    logic       ref_has_pin_i = 1'b1;
    logic       qualified_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    fsq_top uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_pin_i    (sync_pin_i),
        .tick_i        (tick_i),
        .ext_en_i      (ext_en_i),
        .src_sel_i     (src_sel_i),
        .ref_has_pin_i (ref_has_pin_i),
        .qualified_o   (qualified_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: pin history queue, hit counter, flag
    logic [2:0] hist[$];
    bit m_prev = 1;
    int m_run = 0;
    bit m_live = 0;
    bit m_q = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b111, 3'b111};
            m_prev = 1; m_run = 0; m_live = 0; m_q = 0;
        end else begin
            bit act, lvl, fl;
            logic [2:0] seen;
            seen = hist[1];
            act = ext_en_i && ref_has_pin_i && (src_sel_i < 3);
            lvl = act ? seen[src_sel_i] : 1'b1;
            fl = m_prev && !lvl;
            if (!act) begin
                m_live = 0; m_run = 0;
            end else if (!m_live) begin
                m_live = 1; m_run = 0;
            end else if (tick_i) begin
                if (fl) m_run = (m_run < RUN) ? m_run + 1 : RUN;
                else    m_run = 0;
            end
            m_q = act && m_live && (m_run >= RUN);
            m_prev = lvl;
            hist.push_front(sync_pin_i);
            void'(hist.pop_back());
        end
    end

    task automatic check(input string req, input bit exp);
        n_checks++;
        if (qualified_o !== exp) begin
            n_fail++;
            $display("FAIL %s: qualified_o=%b expected %b at %0t", req, qualified_o, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) check({cur_req, " model"}, m_q);
    end

    // mode 0: fall two cycles before tick (+off), 1: held low, 2: inverted
    task automatic periods(input int n, input logic [2:0] mask, input int off,
                           input int mode, input logic idle);
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < PER; c++) begin
                logic lvl;
                @(negedge clk);
                lvl = (c >= 5 + off || c < 1) ? 1'b0 : 1'b1;
                if (mode == 1) lvl = 1'b0;
                if (mode == 2) lvl = ~lvl;
                for (int i = 0; i < 3; i++) sync_pin_i[i] = mask[i] ? lvl : idle;
                tick_i = (c == PER - 1);
            end
        end
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        cur_req = "R3";
        periods(RUN - 1, 3'b001, 0, 0, 1'b1);
        check("R3", 1'b0);
        periods(1, 3'b001, 0, 0, 1'b1);
        check("R3", 1'b1);

        cur_req = "R10";
        periods(10, 3'b001, 0, 0, 1'b1);
        check("R10", 1'b1);

        cur_req = "R4";
        periods(1, 3'b001, 0, 1, 1'b1);
        check("R4", 1'b0);

        cur_req = "R2";
        periods(RUN + 4, 3'b001, 0, 2, 1'b1);
        check("R2", 1'b0);

        cur_req = "R5";
        periods(RUN + 4, 3'b001, 1, 0, 1'b1);
        check("R5", 1'b0);
        periods(RUN + 4, 3'b001, -1, 0, 1'b1);
        check("R5", 1'b0);

        cur_req = "R6";
        periods(RUN, 3'b001, 0, 0, 1'b1);
        check("R6", 1'b1);
        periods(1, 3'b001, -1, 0, 1'b1);
        check("R6", 1'b0);
        periods(RUN - 1, 3'b001, 0, 0, 1'b1);
        check("R6", 1'b0);
        periods(1, 3'b001, 0, 0, 1'b1);
        check("R6", 1'b1);

        cur_req = "R7";
        ext_en_i = 1'b0;
        @(negedge clk);
        check("R7", 1'b0);
        periods(RUN + 4, 3'b001, 0, 0, 1'b1);
        check("R7", 1'b0);
        ext_en_i = 1'b1;

        cur_req = "R9";
        ref_has_pin_i = 1'b0;
        periods(RUN + 4, 3'b111, 0, 0, 1'b1);
        check("R9", 1'b0);
        ref_has_pin_i = 1'b1;
        src_sel_i = 2'd3;
        periods(RUN + 4, 3'b111, 0, 0, 1'b1);
        check("R9", 1'b0);

        cur_req = "R8";
        src_sel_i = 2'd2;
        periods(RUN, 3'b100, 0, 0, 1'b0);
        check("R8", 1'b1);
        periods(1, 3'b011, 0, 0, 1'b1);
        check("R8", 1'b0);
        src_sel_i = 2'd1;
        periods(RUN, 3'b010, 0, 0, 1'b1);
        check("R8", 1'b1);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule